// File: doc/BRIEF.md
# Panned Time-Slot Stereo Mixer

This block mixes up to eight mono sample streams into one stereo pair. A slot counter visits the active channels one per clock cycle, always in index order starting at channel 0. The channel being visited sees its ready line high. If that channel offers a sample in the same cycle, the sample is taken. If it offers nothing, the slot counts as silence.

Each taken sample is split between the left and right sides according to a 3-bit pan code held for that channel. The split uses a divide by seven built from shifts and adds. Once every active channel has had its slot, the two side sums are saturated to the output width and presented together with a single-cycle strobe. They then stay unchanged until the next strobe.

Software or a sequencer picks one, two, four or eight active channels. A new count never cuts into a frame that is already running: it is adopted only when the frame's last slot is served.

Top module: `pan_tdm_mixer`

## Requirements
- R1: `cfg_count` selects the number of active channels: code 0 gives 1 channel, 1 gives 2, 2 gives 4 and 3 gives 8. A frame is the run of slots from channel 0 up to the last active channel.
- R2: Exactly one bit of `in_ready` is high in every cycle, the bit of the channel whose slot it is. After a channel's slot comes the next higher channel; after the last active channel comes channel 0.
- R3: A sample is taken from the served channel when its `in_valid` bit is high in its slot. If that bit is low, the value zero is used for that slot.
- R4: For pan code p (bits [3k+2:3k] of `pan_pos` for channel k) and signed 8-bit sample s, the left contribution is s*(7-p)/7 and the right contribution is s*p/7, both truncated toward zero. Code 0 therefore sends everything left and code 7 everything right.
- R5: The channel count in force for a frame is the `cfg_count` value present in the cycle in which the previous frame's last slot was served. A change in any other cycle does not alter the running frame.
- R6: If the last slot of a frame is served in clock cycle n, `out_strobe` is high in cycle n+2 and low in every cycle not produced this way. `out_left` and `out_right` change only together with the strobe.
- R7: `out_left` and `out_right` are the 12-bit signed sums of the frame's left and right contributions, clipped to the output range (no clipping can occur at the default widths).
- R8: While `rst_n` is low, `out_strobe`, `out_left` and `out_right` are 0, the block runs with one active channel, and the slot is channel 0.
- R9: Samples offered on channels outside the current slot, or on channels beyond the active count, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_count | input | 2 | Active channel count code |
| pan_pos | input | 24 | Per-channel 3-bit pan codes, channel k at bits [3k+2:3k] |
| in_valid | input | 8 | Per-channel sample offered |
| in_data | input | 64 | Per-channel signed 8-bit samples, channel k at bits [8k+7:8k] |
| in_ready | output | 8 | One-hot slot grant |
| out_strobe | output | 1 | One-cycle frame result strobe |
| out_left | output | 12 | Signed left frame sum |
| out_right | output | 12 | Signed right frame sum |

## Verification
On every cycle, the embedded properties check the following:
- the slot counter steps and wraps correctly;
- the grant is one-hot;
- the count code is held steady until a frame's last slot;
- a missing handshake turns into a zero sample;
- each divide by seven is exact and the two pan shares never exceed the sample's size;
- the strobe follows only a last slot, and the outputs stay still between strobes.

Only the bench's scenarios can show that the frame sums carry the right numbers. They run pan extremes with minimum-value samples, all-silent frames, traffic offered on channels that are not being served, and count changes that land mid-frame at random points, and compare each strobed pair against sums computed independently.

// File: rtl/pan_mix_pkg.sv
package pan_mix_pkg;

   localparam int CODE_W       = 2;     // width of the channel count code
   localparam int POS_W        = 3;     // width of a pan code
   localparam int GAIN_FULL    = 7;     // pan code of a full-right channel
   localparam int RECIP7_MUL   = 2341;  // ceil(2^14 / 7)
   localparam int RECIP7_SHIFT = 14;

   typedef enum logic [CODE_W-1:0] {
      CNT_ONE   = 2'd0,
      CNT_TWO   = 2'd1,
      CNT_FOUR  = 2'd2,
      CNT_EIGHT = 2'd3
   } count_code_e;

   // Limit a requested count code to what the instance can serve.
   function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] req,
                                                    input int unsigned max_code);
      if (int'(req) > int'(max_code)) return CODE_W'(max_code);
      return req;
   endfunction

endpackage

// File: rtl/pan_mix_sched.sv
module pan_mix_sched
   import pan_mix_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CODE_W-1:0]    cfg_count,
   output logic [IDX_W-1:0]     slot_idx,
   output logic                 slot_last,
   output logic [NUM_CH-1:0]    ready_vec
);

   localparam int unsigned MAX_CODE = IDX_W;

   logic [CODE_W-1:0] act_code;
   logic [IDX_W-1:0]  last_idx;

   assign last_idx  = IDX_W'((1 << act_code) - 1);
   assign slot_last = (slot_idx == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_idx <= '0;
         act_code <= CNT_ONE;
      end else if (slot_last) begin
         slot_idx <= '0;
         act_code <= clamp_code(cfg_count, MAX_CODE);
      end else begin
         slot_idx <= slot_idx + 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
      assign ready_vec[i] = (slot_idx == IDX_W'(i));
   end

   AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(ready_vec));                                              // R2
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> slot_idx == $past(slot_idx) + 1'b1);               // R2
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      slot_last |=> slot_idx == '0);                                    // R2
   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_idx <= last_idx);                                            // R1
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_last |=> $stable(act_code));                                // R5

endmodule

// File: rtl/pan_mix_scale.sv
module pan_mix_scale
   import pan_mix_pkg::*;
#(
   parameter int SAMPLE_W = 8
) (
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic        [POS_W-1:0]    gain_i,
   output logic signed [SAMPLE_W-1:0] term_o
);

   localparam int PROD_W  = SAMPLE_W + POS_W;
   localparam int RECIP_W = PROD_W + RECIP7_SHIFT;

   // The reciprocal stays exact only while |sample|*7 stays below 5461.
   if (SAMPLE_W < 2 || SAMPLE_W > 10) begin : g_bad_width
      $error("pan_mix_scale: SAMPLE_W must lie in 2..10");
   end

   logic                neg;
   logic [SAMPLE_W-1:0] mag;
   logic [PROD_W-1:0]   part [POS_W];
   logic [PROD_W-1:0]   prod;
   logic [RECIP_W-1:0]  rterm [RECIP7_SHIFT];
   logic [RECIP_W-1:0]  scaled;
   logic [SAMPLE_W-1:0] quot;

   assign neg = sample_i[SAMPLE_W-1];
   assign mag = neg ? (~sample_i + 1'b1) : sample_i;

   // magnitude times pan gain, one shifted copy per gain bit
   for (genvar j = 0; j < POS_W; j++) begin : g_gain_bit
      assign part[j] = gain_i[j] ? (PROD_W'(mag) << j) : '0;
   end

   always_comb begin
      prod = '0;
      for (int j = 0; j < POS_W; j++) prod = prod + part[j];
   end

   // multiply by the reciprocal of seven, one shifted copy per set bit
   for (genvar k = 0; k < RECIP7_SHIFT; k++) begin : g_recip_bit
      if (RECIP7_MUL[k]) begin : g_on
         assign rterm[k] = RECIP_W'(prod) << k;
      end else begin : g_off
         assign rterm[k] = '0;
      end
   end

   always_comb begin
      scaled = '0;
      for (int k = 0; k < RECIP7_SHIFT; k++) scaled = scaled + rterm[k];
   end

   assign quot   = SAMPLE_W'(scaled >> RECIP7_SHIFT);
   assign term_o = neg ? -$signed(quot) : $signed(quot);

   always_comb begin
      AST_DIV_EXACT: assert ((int'(quot) * GAIN_FULL <= int'(prod)) &&
                             (int'(prod) - int'(quot) * GAIN_FULL < GAIN_FULL)); // R4
   end

endmodule

// File: rtl/pan_mix_accum.sv
module pan_mix_accum #(
   parameter int SAMPLE_W = 8,
   parameter int ACC_W    = 12,
   parameter int OUT_W    = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       term_valid,
   input  logic                       term_last,
   input  logic signed [SAMPLE_W-1:0] term_l,
   input  logic signed [SAMPLE_W-1:0] term_r,
   output logic                       out_stb,
   output logic signed [OUT_W-1:0]    out_l,
   output logic signed [OUT_W-1:0]    out_r
);

   if (ACC_W <= SAMPLE_W) begin : g_bad_acc
      $error("pan_mix_accum: ACC_W must exceed SAMPLE_W");
   end

   logic signed [SAMPLE_W-1:0] term  [2];
   logic signed [OUT_W-1:0]    out_q [2];
   logic                       close_frame;

   assign term[0]     = term_l;
   assign term[1]     = term_r;
   assign close_frame = term_valid && term_last;

   for (genvar s = 0; s < 2; s++) begin : g_side
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] sum;
      logic signed [OUT_W-1:0] clip;

      assign sum = acc + ACC_W'(term[s]);

      if (ACC_W > OUT_W) begin : g_clip
         localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (OUT_W - 1)) - 1);
         localparam logic signed [ACC_W-1:0] LO = ~HI;
         assign clip = (sum > HI) ? OUT_W'(HI) :
                       (sum < LO) ? OUT_W'(LO) : OUT_W'(sum);
      end else begin : g_extend
         assign clip = OUT_W'(sum);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc      <= '0;
            out_q[s] <= '0;
         end else if (term_valid) begin
            if (term_last) begin
               acc      <= '0;
               out_q[s] <= clip;
            end else begin
               acc <= sum;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_stb <= 1'b0;
      else        out_stb <= close_frame;
   end

   assign out_l = out_q[0];
   assign out_r = out_q[1];

   AST_STB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      close_frame |=> out_stb);                                         // R6
   AST_STB_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      !close_frame |=> !out_stb);                                       // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !close_frame |=> ($stable(out_l) && $stable(out_r)));             // R6

endmodule

// File: rtl/pan_tdm_mixer.sv
module pan_tdm_mixer
   import pan_mix_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 8,
   parameter int OUT_W    = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  cfg_count,
   input  logic [NUM_CH*3-1:0]         pan_pos,
   input  logic [NUM_CH-1:0]           in_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]  in_data,
   output logic [NUM_CH-1:0]           in_ready,
   output logic                        out_strobe,
   output logic signed [OUT_W-1:0]     out_left,
   output logic signed [OUT_W-1:0]     out_right
);

   localparam int IDX_W = $clog2(NUM_CH);
   localparam int ACC_W = SAMPLE_W + IDX_W + 1;

   if (NUM_CH != 2 && NUM_CH != 4 && NUM_CH != 8) begin : g_bad_ch
      $error("pan_tdm_mixer: NUM_CH must be 2, 4 or 8");
   end
   if (OUT_W < SAMPLE_W) begin : g_bad_out
      $error("pan_tdm_mixer: OUT_W must not be below SAMPLE_W");
   end

   logic [IDX_W-1:0]           slot_idx;
   logic                       slot_last;
   logic                       sel_valid;
   logic signed [SAMPLE_W-1:0] sel_data;
   logic [POS_W-1:0]           sel_pos;

   pan_mix_sched #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_count (cfg_count),
      .slot_idx  (slot_idx),
      .slot_last (slot_last),
      .ready_vec (in_ready)
   );

   // route the served channel onto the slot bus
   always_comb begin
      sel_valid = in_valid[slot_idx];
      sel_data  = in_data[slot_idx*SAMPLE_W +: SAMPLE_W];
      sel_pos   = pan_pos[slot_idx*POS_W +: POS_W];
   end

   logic                       s1_valid;
   logic                       s1_last;
   logic signed [SAMPLE_W-1:0] s1_sample;
   logic [POS_W-1:0]           s1_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_last   <= 1'b0;
         s1_sample <= '0;
         s1_pos    <= '0;
      end else begin
         s1_valid  <= 1'b1;
         s1_last   <= slot_last;
         s1_sample <= sel_valid ? sel_data : '0;
         s1_pos    <= sel_pos;
      end
   end

   logic [POS_W-1:0]           side_gain [2];
   logic signed [SAMPLE_W-1:0] side_term [2];

   assign side_gain[0] = POS_W'(GAIN_FULL) - s1_pos;
   assign side_gain[1] = s1_pos;

   for (genvar s = 0; s < 2; s++) begin : g_pan
      pan_mix_scale #(.SAMPLE_W(SAMPLE_W)) u_scale (
         .sample_i (s1_sample),
         .gain_i   (side_gain[s]),
         .term_o   (side_term[s])
      );
   end

   pan_mix_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .term_valid (s1_valid),
      .term_last  (s1_last),
      .term_l     (side_term[0]),
      .term_r     (side_term[1]),
      .out_stb    (out_strobe),
      .out_l      (out_left),
      .out_r      (out_right)
   );

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(in_valid & in_ready)) |=> (s1_sample == '0));                 // R3

   always_comb begin
      AST_PAN_BOUND: assert ((side_term[0] < 0 ? -int'(side_term[0]) : int'(side_term[0])) +
                             (side_term[1] < 0 ? -int'(side_term[1]) : int'(side_term[1])) <=
                             (s1_sample < 0 ? -int'(s1_sample) : int'(s1_sample))); // R4
   end

endmodule

// File: tb/pan_tdm_mixer_test.sv
module pan_tdm_mixer_test;

   localparam int CLK_HALF = 4;   // 8 ns period, 125 MHz
   localparam int NCH      = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cfg_count = '0;
   logic [NCH*3-1:0]  pan_pos = '0;
   logic [NCH-1:0]    in_valid = '0;
   logic [NCH*8-1:0]  in_data = '0;
   logic [NCH-1:0]    in_ready;
   logic              out_strobe;
   logic signed [11:0] out_left;
   logic signed [11:0] out_right;

   pan_tdm_mixer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_count  (cfg_count),
      .pan_pos    (pan_pos),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .out_strobe (out_strobe),
      .out_left   (out_left),
      .out_right  (out_right)
   );

   always #CLK_HALF clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // model state
   int slot_m = 0, act_m = 1, acc_l = 0, acc_r = 0;
   bit e1_stb = 0, e2_stb = 0;
   int e1_l = 0, e1_r = 0, e2_l = 0, e2_r = 0;
   int held_l = 0, held_r = 0;
   string val_tag = "R4 R7";

   task automatic check(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int clip12(int v);
      if (v > 2047) return 2047;
      if (v < -2048) return -2048;
      return v;
   endfunction

   function automatic int count_of(logic [1:0] code);
      return 1 << code;
   endfunction

   // one model cycle, called after inputs settle between edges
   task automatic step();
      int s, p, wl, wr, cur_l, cur_r;
      bit cur_stb;
      check("R1 R2 R5 ready", int'(in_ready), 1 << slot_m);
      check("R6 strobe", int'(out_strobe), int'(e2_stb));
      if (e2_stb) begin
         held_l = e2_l;
         held_r = e2_r;
      end
      check({val_tag, " left"}, int'(out_left), held_l);
      check({val_tag, " right"}, int'(out_right), held_r);

      s  = in_valid[slot_m] ? int'($signed(in_data[slot_m*8 +: 8])) : 0;
      p  = int'(pan_pos[slot_m*3 +: 3]);
      wl = (s * (7 - p)) / 7;
      wr = (s * p) / 7;
      acc_l += wl;
      acc_r += wr;
      cur_stb = 0; cur_l = 0; cur_r = 0;
      if (slot_m == act_m - 1) begin
         cur_stb = 1;
         cur_l = clip12(acc_l);
         cur_r = clip12(acc_r);
         acc_l = 0; acc_r = 0;
         slot_m = 0;
         act_m = count_of(cfg_count);
      end else begin
         slot_m++;
      end
      e2_stb = e1_stb; e2_l = e1_l; e2_r = e1_r;
      e1_stb = cur_stb; e1_l = cur_l; e1_r = cur_r;
   endtask

   task automatic set_ch(int k, bit v, int d, int p);
      in_valid[k] = v;
      in_data[k*8 +: 8] = 8'(d);
      pan_pos[k*3 +: 3] = 3'(p);
   endtask

   task automatic tick();
      #1;
      step();
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 strobe", int'(out_strobe), 0);
      check("R8 left", int'(out_left), 0);
      check("R8 right", int'(out_right), 0);
      check("R8 slot", int'(in_ready), 1);
      rst_n = 1'b1;

      // R4: one channel, pan extremes with the most negative and positive sample
      val_tag = "R4 R7 extremes";
      cfg_count = 2'd0;
      for (int c = 0; c < 24; c++) begin
         set_ch(0, 1'b1, (c % 2) ? 127 : -128, (c % 4 < 2) ? 0 : 7);
         tick();
      end
      for (int c = 0; c < 16; c++) begin
         set_ch(0, 1'b1, -128 + 17 * c, c % 8);
         tick();
      end

      // R7: eight channels of -128, lowest possible sum
      val_tag = "R7 full scale";
      cfg_count = 2'd3;
      for (int c = 0; c < 40; c++) begin
         for (int k = 0; k < NCH; k++) set_ch(k, 1'b1, -128, (c < 20) ? 0 : 7);
         tick();
      end

      // R3: nothing offered, zeros expected
      val_tag = "R3 silent";
      cfg_count = 2'd2;
      for (int c = 0; c < 24; c++) begin
         for (int k = 0; k < NCH; k++) set_ch(k, 1'b0, 100, 3);
         tick();
      end

      // R9: only channel 0 served; traffic on the others must not leak
      val_tag = "R9 unserved";
      cfg_count = 2'd1;
      for (int c = 0; c < 8; c++) tick();
      cfg_count = 2'd0;
      for (int c = 0; c < 24; c++) begin
         set_ch(0, 1'b1, 0, 5);
         for (int k = 1; k < NCH; k++) set_ch(k, 1'b1, 120, 7);
         tick();
      end

      // R5 mixed with random traffic: count changes land at random cycles
      val_tag = "R4 R5 R7 random";
      for (int c = 0; c < 3000; c++) begin
         if ($urandom_range(15, 0) == 0) cfg_count = 2'($urandom_range(3, 0));
         for (int k = 0; k < NCH; k++)
            set_ch(k, ($urandom_range(3, 0) != 0), int'($urandom_range(255, 0)) - 128,
                   int'($urandom_range(7, 0)));
         tick();
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule